// File: doc/BRIEF.md
# Burst ROM Read Controller

This controller drives an external read-only memory that can return words in fast bursts. It serves two address areas, and each area can be set up on its own to run in burst mode. When the CPU reads from an area in burst mode, the controller first runs one long access. This initial access is as long as the area's normal access timing. It then serves each following sequential read with a short burst cycle of fixed length. While the burst runs, the chip select stays asserted and no wait is allowed.

Writes, non-CPU accesses and reads to an area that is not in burst mode each run as a single long access. A burst ends in any of these cases:
- the block of words is used up;
- the CPU breaks the address sequence;
- the CPU changes area.

After a burst ends, the next access starts again with a long access.

The controller has four states:
- IDLE: no access is running. A request is accepted at once and moves the controller to FULL.
- FULL: the initial access. It counts down the area's initial-state setting. While the wait input is high in the last state, that state is extended. At its end the controller moves to BURST if a matching sequential read is already waiting. It moves to HOLD if the burst can go on but no request is pending. Otherwise it moves to IDLE.
- BURST: one burst cycle. It counts down the area's burst-cycle setting and ignores the wait input. When it ends, the controller takes the same three-way choice as at the end of FULL.
- HOLD: the burst is open and the controller waits for the CPU. A matching request moves it to BURST. A request that does not match, or a cleared area enable, moves it to IDLE.

Top module: `brom_ctrl`

## Requirements
- R1: After reset, both chip selects (active low) and both strobes are high. `data_valid` and `req_ready` are low while no request is presented.
- R2: An area takes part in burst mode only when its bit in `cfg_burst_en` is 1. A read to an area whose bit is 0 ends after one access, and the next read to that area is again a full access.
- R3: The 2-bit per-area length field (area a at bits [2a+1:2a]) selects a block of 4, 8, 16 or 32 words for codes 0, 1, 2 and 3. After that many words the burst closes, and the next sequential read takes one idle cycle and then a full access.
- R4: The 3-bit per-area burst-cycle field (area a at bits [3a+2:3a]) with value b makes every burst cycle last b+1 clocks. The cycle is counted from the clock after acceptance up to and including the `data_valid` clock.
- R5: `ext_wait` has no effect during a burst cycle. During an initial access, each clock with `ext_wait` high in the last state adds one clock.
- R6: The 4-bit per-area initial field (area a at bits [4a+3:4a]) with value n makes the initial access last n+1 clocks after acceptance, plus any wait clocks.
- R7: A write, or a read with `req_cpu` low, runs as a single full access even in a burst-enabled area. `rom_wr_n` is low during a write. The next read then takes one idle cycle and a full access.
- R8: The two areas take their enable, length, burst-cycle and initial settings only from their own fields.
- R9: A burst read is accepted only at the address whose upper bits equal the previous word's and whose low index is the previous index plus one, modulo the block size. `rom_addr` presents the accepted address.
- R10: A non-sequential address or a change of area ends an open burst. The controller takes one idle cycle and then a full access.
- R11: Only the chip select of the active area is asserted. It stays low together with `rom_rd_n` for the whole burst, including the waiting gaps between burst cycles.
- R12: `data_valid` pulses for one clock at the last state of every access. `rd_data` equals `rom_data` in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_burst_en | input | NAREA | Burst-mode enable, one bit per area |
| cfg_len | input | NAREA*LW | Burst block size code per area |
| cfg_bcyc | input | NAREA*BW | Burst cycle length minus one, per area |
| cfg_init | input | NAREA*IW | Initial access length minus one, per area |
| req_valid | input | 1 | Access request, held until `req_ready` |
| req_write | input | 1 | Request is a write |
| req_cpu | input | 1 | Request comes from the CPU |
| req_area | input | AREA_W | Target area of the request |
| req_addr | input | AW | Word address of the request |
| ext_wait | input | 1 | External wait, used only in the initial access |
| rom_data | input | DW | Data returned by the memory |
| req_ready | output | 1 | Request accepted in this clock |
| rom_addr | output | AW | Address to the memory |
| rom_cs_n | output | NAREA | Chip select per area, active low |
| rom_rd_n | output | 1 | Read strobe, active low |
| rom_wr_n | output | 1 | Write strobe, active low |
| data_valid | output | 1 | Last state of an access |
| rd_data | output | DW | Read data, valid with `data_valid` |

## Verification
Two functions can fall in the same clock: the end of one word (`data_valid`) and the acceptance of the next sequential burst read (`req_ready`). The bench provokes this by presenting the next request at the very edge where it sees `data_valid`. It then judges from the stall count that the request was taken in that clock, and from the following cycle count that the burst cycle started at once. A second overlap is an `ext_wait` raised during a burst cycle at the same time as that cycle ends. The bench checks that the end still comes at b+1 clocks.

// File: rtl/brom_pkg.sv
package brom_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FULL  = 2'd1,
        ST_BURST = 2'd2,
        ST_HOLD  = 2'd3
    } brom_state_e;

endpackage

// File: rtl/brom_field_mux.sv
module brom_field_mux #(
    parameter int N  = 2,
    parameter int FW = 3,
    parameter int SW = 1
) (
    input  logic [N*FW-1:0] fields,
    input  logic [SW-1:0]   sel,
    output logic [FW-1:0]   field
);

    logic [FW-1:0] slot [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign slot[g] = fields[g*FW +: FW];
    end

    always_comb begin
        field = '0;
        for (int i = 0; i < N; i++) begin
            if (SW'(i) == sel) begin
                field = slot[i];
            end
        end
    end

endmodule

// File: rtl/brom_seq_match.sv
module brom_seq_match #(
    parameter int AW = 16,
    parameter int LW = 2
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] len_code,
    output logic [AW-1:0] blk_mask,
    output logic          hit
);

    logic [AW-1:0] span;
    logic [AW-1:0] next_addr;

    always_comb begin
        span      = AW'(4) << len_code;
        blk_mask  = span - AW'(1);
        next_addr = (cur_addr & ~blk_mask) | ((cur_addr + AW'(1)) & blk_mask);
        hit       = (req_addr == next_addr);
    end

endmodule

// File: rtl/brom_down_cnt.sv
module brom_down_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         zero
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/brom_ctrl.sv
module brom_ctrl
    import brom_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int NAREA = 2,
    parameter int IW    = 4,
    parameter int BW    = 3,
    parameter int LW    = 2,
    localparam int AREA_W = (NAREA > 1) ? $clog2(NAREA) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NAREA-1:0]      cfg_burst_en,
    input  logic [NAREA*LW-1:0]   cfg_len,
    input  logic [NAREA*BW-1:0]   cfg_bcyc,
    input  logic [NAREA*IW-1:0]   cfg_init,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  req_cpu,
    input  logic [AREA_W-1:0]     req_area,
    input  logic [AW-1:0]         req_addr,
    input  logic                  ext_wait,
    input  logic [DW-1:0]         rom_data,
    output logic                  req_ready,
    output logic [AW-1:0]         rom_addr,
    output logic [NAREA-1:0]      rom_cs_n,
    output logic                  rom_rd_n,
    output logic                  rom_wr_n,
    output logic                  data_valid,
    output logic [DW-1:0]         rd_data
);

    localparam int CW   = (IW > BW) ? IW : BW;
    localparam int MAXW = 4 << ((1 << LW) - 1);
    localparam int WCW  = $clog2(MAXW) + 1;

    brom_state_e state_q, state_d;

    logic [AW-1:0]     addr_q;
    logic [AREA_W-1:0] area_q;
    logic              wr_q;
    logic              cpu_q;
    logic [WCW-1:0]    words_q;

    logic              cur_en;
    logic [LW-1:0]     cur_len;
    logic [BW-1:0]     cur_bcyc;
    logic [IW-1:0]     req_init;
    logic [WCW-1:0]    cur_words;
    logic [AW-1:0]     blk_mask;
    logic              seq_hit;
    logic              seq_ok;
    logic              keep_open;
    logic              word_end;
    logic              take_full;
    logic              take_burst;
    logic              cnt_load;
    logic [CW-1:0]     cnt_val;
    logic [CW-1:0]     cnt;
    logic              cnt_zero;
    logic              active;

    // per-area settings: the open burst uses its own area, a new access the requested one (R8)
    brom_field_mux #(.N(NAREA), .FW(1), .SW(AREA_W)) u_mux_en (
        .fields(cfg_burst_en), .sel(area_q), .field(cur_en)
    );
    brom_field_mux #(.N(NAREA), .FW(LW), .SW(AREA_W)) u_mux_len (
        .fields(cfg_len), .sel(area_q), .field(cur_len)
    );
    brom_field_mux #(.N(NAREA), .FW(BW), .SW(AREA_W)) u_mux_bcyc (
        .fields(cfg_bcyc), .sel(area_q), .field(cur_bcyc)
    );
    brom_field_mux #(.N(NAREA), .FW(IW), .SW(AREA_W)) u_mux_init (
        .fields(cfg_init), .sel(req_area), .field(req_init)
    );

    brom_seq_match #(.AW(AW), .LW(LW)) u_seq (
        .cur_addr(addr_q),
        .req_addr(req_addr),
        .len_code(cur_len),
        .blk_mask(blk_mask),
        .hit(seq_hit)
    );

    assign cnt_load = take_full | take_burst;
    assign cnt_val  = take_full ? CW'(req_init) : CW'(cur_bcyc);

    brom_down_cnt #(.W(CW)) u_cnt (
        .clk(clk),
        .rst_n(rst_n),
        .load(cnt_load),
        .load_val(cnt_val),
        .cnt(cnt),
        .zero(cnt_zero)
    );

    assign cur_words = WCW'(4) << cur_len;
    assign keep_open = cur_en && !wr_q && cpu_q && (words_q < cur_words);
    assign seq_ok    = !req_write && req_cpu && (req_area == area_q) && seq_hit;
    // wait only stretches the initial access (R5)
    assign word_end  = ((state_q == ST_FULL) && cnt_zero && !ext_wait) ||
                       ((state_q == ST_BURST) && cnt_zero);

    // next-state logic
    always_comb begin
        state_d    = state_q;
        take_full  = 1'b0;
        take_burst = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    take_full = 1'b1;
                    state_d   = ST_FULL;
                end
            end
            ST_FULL, ST_BURST: begin
                if (word_end) begin
                    if (keep_open && req_valid && seq_ok) begin
                        take_burst = 1'b1;
                        state_d    = ST_BURST;
                    end else if (keep_open && !req_valid) begin
                        state_d = ST_HOLD;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                if (!keep_open) begin
                    state_d = ST_IDLE;
                end else if (req_valid) begin
                    if (seq_ok) begin
                        take_burst = 1'b1;
                        state_d    = ST_BURST;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // access context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            area_q  <= '0;
            wr_q    <= 1'b0;
            cpu_q   <= 1'b0;
            words_q <= '0;
        end else if (take_full) begin
            addr_q  <= req_addr;
            area_q  <= req_area;
            wr_q    <= req_write;
            cpu_q   <= req_cpu;
            words_q <= WCW'(1);
        end else if (take_burst) begin
            addr_q  <= req_addr;
            words_q <= words_q + WCW'(1);
        end
    end

    // outputs
    always_comb begin
        active     = (state_q != ST_IDLE);
        rom_addr   = addr_q;
        rom_cs_n   = '1;
        if (active) begin
            rom_cs_n[area_q] = 1'b0;
        end
        rom_rd_n   = !(active && !wr_q);
        rom_wr_n   = !((state_q == ST_FULL) && wr_q);
        data_valid = word_end;
        rd_data    = rom_data;
        req_ready  = take_full | take_burst;
    end

    // R4, R5: a burst cycle counts down every clock whatever ext_wait does
    a_r4_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !cnt_zero) |=> (cnt == $past(cnt) - CW'(1)));

    // R3: never more words in one burst than the block holds
    a_r3_len_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (words_q <= cur_words));

    // R9: upper address bits stay put across a burst step
    a_r9_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        take_burst |=> ((addr_q & ~$past(blk_mask)) == ($past(addr_q) & ~$past(blk_mask))));

    // R7: a write never leaves a burst open
    a_r7_write_single: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && wr_q) |=> (state_q == ST_IDLE));

    // R10: an unmatched request while holding closes the burst
    a_r10_break: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && req_valid && !req_ready) |=> (state_q == ST_IDLE));

    // R11: at most one area selected
    a_r11_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~rom_cs_n));

endmodule

// File: tb/brom_ctrl_tb.sv
module brom_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_burst_en = '0;
    logic [3:0]  cfg_len = '0;
    logic [5:0]  cfg_bcyc = '0;
    logic [7:0]  cfg_init = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_cpu = 1'b1;
    logic [0:0]  req_area = '0;
    logic [15:0] req_addr = '0;
    logic        ext_wait = 1'b0;
    logic [15:0] rom_data;
    logic        req_ready;
    logic [15:0] rom_addr;
    logic [1:0]  rom_cs_n;
    logic        rom_rd_n;
    logic        rom_wr_n;
    logic        data_valid;
    logic [15:0] rd_data;

    int errors = 0;
    int checks = 0;
    int init_of [2];

    always #4 clk = ~clk;

    assign rom_data = {rom_addr[7:0], ~rom_addr[7:0]};

    brom_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_burst_en(cfg_burst_en), .cfg_len(cfg_len),
        .cfg_bcyc(cfg_bcyc), .cfg_init(cfg_init),
        .req_valid(req_valid), .req_write(req_write), .req_cpu(req_cpu),
        .req_area(req_area), .req_addr(req_addr), .ext_wait(ext_wait),
        .rom_data(rom_data), .req_ready(req_ready), .rom_addr(rom_addr),
        .rom_cs_n(rom_cs_n), .rom_rd_n(rom_rd_n), .rom_wr_n(rom_wr_n),
        .data_valid(data_valid), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_area(input int a, input bit en, input int len,
                            input int b, input int n);
        cfg_burst_en[a]      = en;
        cfg_len[a*2 +: 2]    = 2'(len);
        cfg_bcyc[a*3 +: 3]   = 3'(b);
        cfg_init[a*4 +: 4]   = 4'(n);
        init_of[a]           = n;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // one access: checks stall before acceptance, clocks to data_valid, address and data
    task automatic access(input int area, input logic [15:0] addr, input bit wr,
                          input bit cpu, input int exp_stall, input int exp_len,
                          input int wextra, input bit wburst, input string req);
        int stall = 0;
        int len = 0;
        req_valid = 1'b1;
        req_area  = 1'(area);
        req_addr  = addr;
        req_write = wr;
        req_cpu   = cpu;
        ext_wait  = (wextra > 0);
        #1;
        while (!req_ready && stall < 100) begin
            @(negedge clk);
            #1;
            stall++;
        end
        do begin
            @(negedge clk);
            if (len == 0) begin
                req_valid = 1'b0;
                if (wburst) ext_wait = 1'b1;
            end
            len++;
            if (!wburst && len >= exp_len) ext_wait = 1'b0;
            #1;
        end while (!data_valid && len < 100);
        chk(stall == exp_stall, req, "stall before accept", stall, exp_stall);
        chk(len == exp_len, req, "clocks to data_valid", len, exp_len);
        chk(rom_cs_n[area] == 1'b0, "R11", "cs low at data_valid", int'(rom_cs_n), area);
        if (wr) begin
            chk(rom_wr_n == 1'b0, "R7", "write strobe", int'(rom_wr_n), 0);
        end else begin
            chk(rom_rd_n == 1'b0, "R11", "read strobe", int'(rom_rd_n), 0);
            chk(rom_addr == addr, "R9", "rom_addr", int'(rom_addr), int'(addr));
            chk(rd_data == {addr[7:0], ~addr[7:0]}, "R12", "rd_data",
                int'(rd_data), int'({addr[7:0], ~addr[7:0]}));
        end
        ext_wait = 1'b0;
    endtask

    // ends any open burst with a single non-CPU read
    task automatic close_burst(input int area);
        access(area, 16'h0100, 1'b0, 1'b0, 1, init_of[area] + 1, 0, 1'b0, "R7");
        idle(2);
    endtask

    task automatic t_reset;
        idle(1);
        chk(rom_cs_n == 2'b11, "R1", "cs after reset", int'(rom_cs_n), 3);
        chk(rom_rd_n == 1'b1, "R1", "rd after reset", int'(rom_rd_n), 1);
        chk(rom_wr_n == 1'b1, "R1", "wr after reset", int'(rom_wr_n), 1);
        chk(data_valid == 1'b0, "R1", "valid after reset", int'(data_valid), 0);
        chk(req_ready == 1'b0, "R1", "ready after reset", int'(req_ready), 0);
    endtask

    // R3, R6, R9: each block size, start near block end so the index wraps
    task automatic t_lengths;
        for (int l = 0; l < 4; l++) begin
            int words = 4 << l;
            int b = l + 3;
            int n = l + 1;
            logic [15:0] base = 16'h5A00 + 16'(l * 64);
            set_area(0, 1'b1, l, b, n);
            set_area(1, 1'b0, 0, 0, 0);
            idle(2);
            for (int k = 0; k < words; k++) begin
                logic [15:0] a = base | 16'((words - 2 + k) % words);
                if (k == 0) access(0, a, 1'b0, 1'b1, 0, n + 1, 0, 1'b0, "R6");
                else        access(0, a, 1'b0, 1'b1, 0, b + 1, 0, 1'b0, "R3");
            end
            access(0, base | 16'(words - 2), 1'b0, 1'b1, 1, n + 1, 0, 1'b0, "R3");
            close_burst(0);
        end
    endtask

    // R4: every burst-cycle setting
    task automatic t_bcyc;
        for (int b = 0; b < 8; b++) begin
            logic [15:0] base = 16'h0300 + 16'(b * 16);
            set_area(0, 1'b1, 0, b, 1);
            idle(2);
            for (int k = 0; k < 4; k++) begin
                logic [15:0] a = base | 16'((1 + k) % 4);
                if (k == 0) access(0, a, 1'b0, 1'b1, 0, 2, 0, 1'b0, "R6");
                else        access(0, a, 1'b0, 1'b1, 0, b + 1, 0, 1'b0, "R4");
            end
            close_burst(0);
        end
    endtask

    // R2, R8: area 1 bursting with its own fields, area 0 disabled
    task automatic t_areas;
        set_area(0, 1'b0, 3, 7, 6);
        set_area(1, 1'b1, 1, 5, 4);
        idle(2);
        access(1, 16'h2004, 1'b0, 1'b1, 0, 5, 0, 1'b0, "R8");
        access(1, 16'h2005, 1'b0, 1'b1, 0, 6, 0, 1'b0, "R8");
        access(1, 16'h2006, 1'b0, 1'b1, 0, 6, 0, 1'b0, "R8");
        close_burst(1);
        access(0, 16'h0040, 1'b0, 1'b1, 0, 7, 0, 1'b0, "R2");
        access(0, 16'h0041, 1'b0, 1'b1, 1, 7, 0, 1'b0, "R2");
        idle(2);
    endtask

    // R10: broken sequence and area change
    task automatic t_breaks;
        set_area(0, 1'b1, 2, 2, 3);
        set_area(1, 1'b1, 0, 1, 5);
        idle(2);
        access(0, 16'h4010, 1'b0, 1'b1, 0, 4, 0, 1'b0, "R10");
        access(0, 16'h4011, 1'b0, 1'b1, 0, 3, 0, 1'b0, "R10");
        access(0, 16'h4016, 1'b0, 1'b1, 1, 4, 0, 1'b0, "R10");
        access(1, 16'h4017, 1'b0, 1'b1, 1, 6, 0, 1'b0, "R10");
        close_burst(1);
    endtask

    // R7: write and non-CPU read bypass burst mode
    task automatic t_bypass;
        set_area(0, 1'b1, 1, 0, 2);
        idle(2);
        access(0, 16'h6000, 1'b1, 1'b1, 0, 3, 0, 1'b0, "R7");
        access(0, 16'h6001, 1'b0, 1'b0, 1, 3, 0, 1'b0, "R7");
        access(0, 16'h6002, 1'b0, 1'b1, 1, 3, 0, 1'b0, "R7");
        access(0, 16'h6003, 1'b0, 1'b1, 0, 1, 0, 1'b0, "R7");
        close_burst(0);
    endtask

    // R5: wait stretches the initial access, is ignored in a burst cycle
    task automatic t_wait;
        set_area(0, 1'b1, 0, 2, 2);
        idle(2);
        access(0, 16'h7000, 1'b0, 1'b1, 0, 6, 3, 1'b0, "R5");
        access(0, 16'h7001, 1'b0, 1'b1, 0, 3, 0, 1'b1, "R5");
        close_burst(0);
    endtask

    // R11: gap between burst words keeps cs and rd low, next word still a burst cycle
    task automatic t_hold;
        set_area(0, 1'b1, 1, 1, 1);
        idle(2);
        access(0, 16'h1230, 1'b0, 1'b1, 0, 2, 0, 1'b0, "R11");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk(rom_cs_n == 2'b10, "R11", "cs held in gap", int'(rom_cs_n), 2);
            chk(rom_rd_n == 1'b0, "R11", "rd held in gap", int'(rom_rd_n), 0);
            chk(data_valid == 1'b0, "R12", "no valid in gap", int'(data_valid), 0);
        end
        access(0, 16'h1231, 1'b0, 1'b1, 0, 2, 0, 1'b0, "R11");
        close_burst(0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_lengths;
        t_bcyc;
        t_areas;
        t_breaks;
        t_bypass;
        t_wait;
        t_hold;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule